// File: doc/BRIEF.md
# DMA Modulo Address Generator

This block holds the source and destination address registers of one DMA channel and steps them after every data beat. Each side has its own transfer unit size, its own increment enable and its own circular-buffer setting, so one side can walk through memory while the other stays on a peripheral register or loops inside a ring buffer.

A non-zero 4-bit modulo code confines that side's address to an aligned power-of-two window. After a step, only the address bits inside the window take the incremented value. The bits above the window keep their old value, so the address wraps back to the start of the window. A global auto-align input forces both sides to step whatever their enables say. A reserved unit-size code raises a configuration error and freezes the affected address. A load strobe writes fresh start addresses into both registers and takes precedence over a step.

Top module: `dma_mod_addr_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released, both `src_addr` and `dst_addr` read 0 until a load or a step changes them.
- R2: When `load` is high at a rising clock edge, `src_addr` and `dst_addr` take `src_start` and `dst_start` after that edge, even when `advance` is high as well.
- R3: When `advance` is high and `load` is low at a rising edge, a side whose increment enable is set and whose modulo code is 0 steps by its unit size in bytes. Size code 0 steps by 4, code 1 by 1 and code 2 by 2.
- R4: With auto-align low, a side whose increment enable is clear keeps its address across a step.
- R5: With `auto_align` high, both sides step by their unit size even when their increment enables are clear.
- R6: Modulo code m from 1 to 15 selects a window of 2^(m+3) bytes, that is 16 bytes up to 256 KB. On a step, the address bits below bit m+3 take the incremented value, and the bits from m+3 upward keep their previous value.
- R7: Source and destination use independent size codes, increment enables and modulo codes. The settings of one side never change the result on the other side.
- R8: Size code 3 is reserved. While either side's size code is 3, `cfg_err` is high in the same cycle, and a step leaves that side's address unchanged.
- R9: With `load` and `advance` both low at an edge, both addresses hold their values.
- R10: With modulo code 0, the step is a plain 32-bit addition that wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Write the start addresses into both registers |
| src_start | input | 32 | Source start address for a load |
| dst_start | input | 32 | Destination start address for a load |
| advance | input | 1 | One beat done: step both addresses |
| src_size | input | 2 | Source unit code (0: 4 bytes, 1: 1 byte, 2: 2 bytes, 3: reserved) |
| dst_size | input | 2 | Destination unit code, same encoding as the source |
| src_inc | input | 1 | Source increment enable |
| dst_inc | input | 1 | Destination increment enable |
| src_mod | input | 4 | Source window code (0: no wrap, m: 2^(m+3) bytes) |
| dst_mod | input | 4 | Destination window code, same encoding as the source |
| auto_align | input | 1 | Force both sides to step |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| cfg_err | output | 1 | A reserved size code is present on either side |

## Verification
The assertions check on every cycle that a load wins over a step, that idle cycles hold both addresses, that a side with its increment off or a reserved size does not move, and that a step never disturbs the bits above the selected window. Only the bench scenarios can show that the exact step amount matches each size code, that the window really wraps to its base at the boundary, and that a plain 32-bit add rolls over at 2^32. Random mixes of settings on both sides, checked against an independent model, give evidence that the two sides do not interfere.

// File: rtl/dmag_pkg.sv
package dmag_pkg;

  typedef enum logic [1:0] {
    UNIT_W32  = 2'd0,
    UNIT_B8   = 2'd1,
    UNIT_H16  = 2'd2,
    UNIT_RSVD = 2'd3
  } unit_code_e;

  // Bytes per beat for a unit code; the reserved code steps by nothing.
  function automatic logic [2:0] unit_bytes(input logic [1:0] code);
    case (code)
      UNIT_W32: return 3'd4;
      UNIT_B8:  return 3'd1;
      UNIT_H16: return 3'd2;
      default:  return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/dmag_step.sv
module dmag_step
  import dmag_pkg::*;
#(
  parameter int AW   = 32,
  parameter int MW   = 4,
  parameter int MINL = 4
) (
  input  logic [AW-1:0] cur,
  input  logic [1:0]    size,
  input  logic          inc_en,
  input  logic          auto_align,
  input  logic [MW-1:0] mod,
  output logic [AW-1:0] nxt,
  output logic          bad_size
);

  logic [AW-1:0] step;
  logic [AW-1:0] sum;
  logic [AW-1:0] low_mask;

  always_comb begin
    bad_size = (size == UNIT_RSVD);
    step     = '0;
    if ((inc_en || auto_align) && !bad_size) begin
      step = AW'(unit_bytes(size));
    end
    sum      = cur + step;
    low_mask = (AW'(1) << (int'(mod) + MINL - 1)) - AW'(1);
    if (mod == '0) begin
      nxt = sum;
    end else begin
      nxt = (cur & ~low_mask) | (sum & low_mask);
    end
  end

endmodule

// File: rtl/dmag_lane.sv
module dmag_lane
  import dmag_pkg::*;
#(
  parameter int AW   = 32,
  parameter int MW   = 4,
  parameter int MINL = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] start,
  input  logic          advance,
  input  logic [1:0]    size,
  input  logic          inc_en,
  input  logic          auto_align,
  input  logic [MW-1:0] mod,
  output logic [AW-1:0] addr,
  output logic          bad_size
);

  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_d;
  logic [AW-1:0] stepped;
  logic          addr_en;

  dmag_step #(.AW(AW), .MW(MW), .MINL(MINL)) u_step (
    .cur        (addr_q),
    .size       (size),
    .inc_en     (inc_en),
    .auto_align (auto_align),
    .mod        (mod),
    .nxt        (stepped),
    .bad_size   (bad_size)
  );

  always_comb begin
    addr_en = load || advance;
    addr_d  = load ? start : stepped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  assign addr = addr_q;

  // Bits at and above the window boundary; zero when wrapping is off.
  function automatic logic [AW-1:0] upper_mask(input logic [MW-1:0] m);
    if (m == '0) return '0;
    return ~((AW'(1) << (int'(m) + MINL - 1)) - AW'(1));
  endfunction

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> addr == $past(start)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !advance) |=> $stable(addr)); // R9

  AST_NO_INC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && advance && !inc_en && !auto_align) |=> $stable(addr)); // R4

  AST_RSVD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && advance && size == UNIT_RSVD) |=> $stable(addr)); // R8

  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && advance && mod != '0) |=>
      ((addr & upper_mask($past(mod))) == ($past(addr) & upper_mask($past(mod))))); // R6

endmodule

// File: rtl/dma_mod_addr_gen.sv
module dma_mod_addr_gen #(
  parameter int AW   = 32,
  parameter int MW   = 4,
  parameter int MINL = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] src_start,
  input  logic [AW-1:0] dst_start,
  input  logic          advance,
  input  logic [1:0]    src_size,
  input  logic [1:0]    dst_size,
  input  logic          src_inc,
  input  logic          dst_inc,
  input  logic [MW-1:0] src_mod,
  input  logic [MW-1:0] dst_mod,
  input  logic          auto_align,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic          cfg_err
);

  localparam int NSIDE = 2;

  logic [AW-1:0] side_start [NSIDE];
  logic [AW-1:0] side_addr  [NSIDE];
  logic [1:0]    side_size  [NSIDE];
  logic          side_inc   [NSIDE];
  logic [MW-1:0] side_mod   [NSIDE];
  logic          side_bad   [NSIDE];

  always_comb begin
    side_start[0] = src_start;  side_start[1] = dst_start;
    side_size[0]  = src_size;   side_size[1]  = dst_size;
    side_inc[0]   = src_inc;    side_inc[1]   = dst_inc;
    side_mod[0]   = src_mod;    side_mod[1]   = dst_mod;
  end

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    dmag_lane #(.AW(AW), .MW(MW), .MINL(MINL)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .start      (side_start[g]),
      .advance    (advance),
      .size       (side_size[g]),
      .inc_en     (side_inc[g]),
      .auto_align (auto_align),
      .mod        (side_mod[g]),
      .addr       (side_addr[g]),
      .bad_size   (side_bad[g])
    );
  end

  assign src_addr = side_addr[0];
  assign dst_addr = side_addr[1];
  assign cfg_err  = side_bad[0] || side_bad[1];

  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_n |-> (src_addr == '0 && dst_addr == '0)); // R1

endmodule

// File: tb/dma_mod_addr_gen_test.sv
module dma_mod_addr_gen_test;

  logic        clk;
  logic        rst_n;
  logic        load;
  logic [31:0] src_start, dst_start;
  logic        advance;
  logic [1:0]  src_size, dst_size;
  logic        src_inc, dst_inc;
  logic [3:0]  src_mod, dst_mod;
  logic        auto_align;
  logic [31:0] src_addr, dst_addr;
  logic        cfg_err;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [31:0] exp_src, exp_dst;

  dma_mod_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .load(load), .src_start(src_start), .dst_start(dst_start),
    .advance(advance), .src_size(src_size), .dst_size(dst_size), .src_inc(src_inc),
    .dst_inc(dst_inc), .src_mod(src_mod), .dst_mod(dst_mod), .auto_align(auto_align),
    .src_addr(src_addr), .dst_addr(dst_addr), .cfg_err(cfg_err)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  // Independent model: window arithmetic done as base plus offset modulo size.
  function automatic logic [31:0] model_next(input logic [31:0] cur, input logic [1:0] sz,
                                             input logic inc, input logic aa, input logic [3:0] m);
    longint unsigned bytes, win, base, off;
    if (sz == 2'd3 || !(inc || aa)) return cur;
    bytes = (sz == 2'd0) ? 4 : (sz == 2'd1) ? 1 : 2;
    if (m == 0) return 32'((longint'(cur) + bytes) % 64'h1_0000_0000);
    win  = 64'd16 << (m - 1);
    base = longint'(cur) - (longint'(cur) % win);
    off  = (longint'(cur) % win + bytes) % win;
    return 32'(base + off);
  endfunction

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Drive at negedge, step both models, then check at the following negedge.
  task automatic beat(input logic ld, input logic adv, input string tag);
    load = ld; advance = adv;
    #1;
    check32({tag, " cfg_err R8"}, {31'd0, cfg_err},
            {31'd0, (src_size == 2'd3) || (dst_size == 2'd3)});
    if (ld) begin
      exp_src = src_start; exp_dst = dst_start;
    end else if (adv) begin
      exp_src = model_next(exp_src, src_size, src_inc, auto_align, src_mod);
      exp_dst = model_next(exp_dst, dst_size, dst_inc, auto_align, dst_mod);
    end
    @(negedge clk);
    check32({tag, " src"}, src_addr, exp_src);
    check32({tag, " dst"}, dst_addr, exp_dst);
    load = 0; advance = 0;
  endtask

  task automatic setup(input logic [1:0] ss, input logic si, input logic [3:0] sm,
                       input logic [1:0] ds, input logic di, input logic [3:0] dm,
                       input logic aa);
    src_size = ss; src_inc = si; src_mod = sm;
    dst_size = ds; dst_inc = di; dst_mod = dm; auto_align = aa;
  endtask

  task automatic start_at(input logic [31:0] s, input logic [31:0] d, input string tag);
    src_start = s; dst_start = d;
    beat(1'b1, 1'b0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int unsigned seed_set;
    seed_set = $urandom(32'd20240611);
    rst_n = 0; load = 0; advance = 0; src_start = 0; dst_start = 0;
    setup(2'd0, 1'b1, 4'd0, 2'd0, 1'b1, 4'd0, 1'b0);
    exp_src = 0; exp_dst = 0;
    repeat (3) @(negedge clk);
    check32("R1 reset src", src_addr, 32'h0);
    check32("R1 reset dst", dst_addr, 32'h0);
    rst_n = 1;
    @(negedge clk);
    check32("R1 after release src", src_addr, 32'h0);

    // R2: load beats advance
    src_start = 32'h2000_0100; dst_start = 32'h4000_0200;
    beat(1'b1, 1'b1, "R2 load+advance");
    // R3: each unit size, no modulo
    setup(2'd0, 1'b1, 4'd0, 2'd1, 1'b1, 4'd0, 1'b0);
    beat(1'b0, 1'b1, "R3 sizes 4/1");
    setup(2'd2, 1'b1, 4'd0, 2'd2, 1'b1, 4'd0, 1'b0);
    beat(1'b0, 1'b1, "R3 sizes 2/2");
    check32("R3 src stepped 4 then 2", src_addr, 32'h2000_0106);
    // R9: idle holds
    beat(1'b0, 1'b0, "R9 idle");
    // R4: increment off
    setup(2'd0, 1'b0, 4'd0, 2'd0, 1'b1, 4'd0, 1'b0);
    beat(1'b0, 1'b1, "R4 src fixed R7");
    // R5: auto-align forces step
    setup(2'd1, 1'b0, 4'd0, 2'd0, 1'b0, 4'd0, 1'b1);
    beat(1'b0, 1'b1, "R5 auto-align");
    // R6: 16-byte window wrap
    start_at(32'h1000_001C, 32'h3000_0000, "R6 load");
    setup(2'd0, 1'b1, 4'd1, 2'd0, 1'b1, 4'd0, 1'b0);
    beat(1'b0, 1'b1, "R6 16B wrap");
    check32("R6 16B base", src_addr, 32'h1000_0010);
    // R6: 256 KB window wrap
    start_at(32'hABC3_FFFC, 32'h0000_0FFF, "R6 load2");
    setup(2'd0, 1'b1, 4'd15, 2'd1, 1'b1, 4'd9, 1'b0);
    beat(1'b0, 1'b1, "R6 256KB wrap R7");
    check32("R6 256KB base", src_addr, 32'hABC0_0000);
    check32("R6 4KB dst wrap", dst_addr, 32'h0000_0000);
    // R10: 32-bit rollover
    start_at(32'hFFFF_FFFE, 32'hFFFF_FFFC, "R10 load");
    setup(2'd2, 1'b1, 4'd0, 2'd0, 1'b1, 4'd0, 1'b0);
    beat(1'b0, 1'b1, "R10 rollover");
    check32("R10 src at zero", src_addr, 32'h0);
    // R8: reserved size holds, other side still steps
    setup(2'd3, 1'b1, 4'd0, 2'd1, 1'b1, 4'd0, 1'b1);
    beat(1'b0, 1'b1, "R8 reserved src");
    setup(2'd0, 1'b1, 4'd0, 2'd3, 1'b1, 4'd2, 1'b0);
    beat(1'b0, 1'b1, "R8 reserved dst");

    // Random mixes on both sides: R3 R4 R5 R6 R7 R8 R10
    for (int i = 0; i < 400; i++) begin
      setup(2'($urandom), 1'($urandom), 4'($urandom), 2'($urandom), 1'($urandom),
            4'($urandom), ($urandom % 8) == 0);
      src_start = $urandom; dst_start = $urandom;
      beat(($urandom % 10) == 0, ($urandom % 4) != 0, "R7 random");
    end

    done = 1;
    finish_run();
  end

endmodule